// File: doc/BRIEF.md
# USB Host Channel Transfer Tracker

This block holds the programmed state of one USB host channel and follows a transfer from enable to finish. Software loads the byte total, the packet total, the starting data PID and the channel characteristics (target address, endpoint, direction, transfer kind, largest packet size, low-speed flag and odd/even frame choice), then pulses an enable request. A packet engine outside this block moves the data. It reports each finished packet and its length with a one-cycle pulse. In response, the tracker counts the remaining packets and bytes down and alternates the data PID.

A transfer ends in one of three ways. If the last packet arrives, or a short IN packet arrives, the block raises its completed and halted pulses together and drops the enable. If software asks for a stop, the block raises halted alone once the packet in flight is finished. After either ending, software may program the channel again. Periodic kinds start only in a frame whose parity matches the odd/even choice.

Top module: `hchan_xfer_tracker`

## Requirements
- R1: During and right after reset, `enabled_o`, `xfer_go_o`, `done_o` and `halted_o` are 0, and the packet count, byte count and PID (`pid_o`) are all 0.
- R2: A `cfg_wr` pulse while the channel is disabled loads every transfer field and characteristic field. The loaded values appear on the outputs after the next clock edge.
- R3: A `cfg_wr` pulse while `enabled_o` is 1 changes no output field.
- R4: When `en_set` arrives while the channel is disabled and the packet count is nonzero, `enabled_o` rises after that edge. For control (kind 00) and bulk (kind 10), `xfer_go_o` rises one edge later. For isochronous (kind 01) and interrupt (kind 11), `xfer_go_o` rises only on an edge where `frame_lsb` equals the odd/even select.
- R5: Each `pkt_done` pulse accepted while `xfer_go_o` is 1 has three effects. The packet count drops by one. The byte count drops by `pkt_len`, saturating at 0. The PID becomes {~pid[1], 0}, so 00 (DATA0) turns into 10 (DATA1) and back. A `pkt_done` while `xfer_go_o` is 0 changes nothing.
- R6: When an accepted packet brings the packet count to zero, `done_o` and `halted_o` are both 1 for one cycle after that edge, and `enabled_o` and `xfer_go_o` fall.
- R7: On an IN channel (`cfg_dir_in`=1), an accepted packet with `pkt_len` below the largest packet size ends the transfer as in R6. On an OUT channel, a short packet does not end the transfer.
- R8: An `en_clr` pulse while `xfer_go_o` is 1 has no effect until the next accepted packet. That packet is counted, then `halted_o` pulses without `done_o` and the channel disables. An `en_clr` before `xfer_go_o` rises produces the halted pulse at the next edge.
- R9: If a stop request and the final packet fall in the same cycle, the final packet takes precedence: `done_o` and `halted_o` pulse together once.
- R10: An `en_set` while the packet count to be used is zero leaves the channel disabled and pulses `done_o` and `halted_o` together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Load configuration fields |
| cfg_bytes | input | BYTE_W | Transfer size in bytes |
| cfg_pkts | input | PKT_W | Number of packets |
| cfg_pid | input | 2 | Starting data PID (00 DATA0, 10 DATA1) |
| cfg_dev_addr | input | 7 | Target device address |
| cfg_ep | input | 4 | Target endpoint number |
| cfg_dir_in | input | 1 | 1 = IN, 0 = OUT |
| cfg_kind | input | 2 | 00 control, 01 isochronous, 10 bulk, 11 interrupt |
| cfg_mps | input | 11 | Largest packet size in bytes |
| cfg_low_speed | input | 1 | Target is low speed |
| cfg_odd_frame | input | 1 | Periodic start frame parity |
| en_set | input | 1 | Enable request pulse |
| en_clr | input | 1 | Stop request pulse |
| frame_lsb | input | 1 | Parity of current frame number |
| pkt_done | input | 1 | One packet finished |
| pkt_len | input | 11 | Bytes moved by that packet |
| enabled_o | output | 1 | Channel enabled |
| xfer_go_o | output | 1 | Packets may be issued |
| bytes_left_o | output | BYTE_W | Remaining bytes |
| pkts_left_o | output | PKT_W | Remaining packets |
| pid_o | output | 2 | Next data PID |
| dev_addr_o | output | 7 | Device address |
| ep_o | output | 4 | Endpoint number |
| dir_in_o | output | 1 | Direction |
| kind_o | output | 2 | Transfer kind |
| mps_o | output | 11 | Largest packet size |
| low_speed_o | output | 1 | Low-speed flag |
| odd_frame_o | output | 1 | Odd/even frame select |
| done_o | output | 1 | Transfer completed pulse |
| halted_o | output | 1 | Channel halted pulse |

## Verification
Two events can fall in the same cycle: a stop request from software and the packet that would finish the transfer anyway. The bench drives `en_clr` and `pkt_done` together on a one-packet transfer. It expects one cycle in which both completed and halted are high, with no extra halted pulse afterwards. It also drives a stop request with a non-final packet. In that case halted must appear without completed, and the packet's count update must still be applied.

// File: rtl/hc_xfer_pkg.sv
package hc_xfer_pkg;

    localparam int ADDR_W = 7;
    localparam int EP_W   = 4;
    localparam int MPS_W  = 11;

    typedef enum logic [1:0] {
        XK_CTRL = 2'b00,
        XK_ISO  = 2'b01,
        XK_BULK = 2'b10,
        XK_INTR = 2'b11
    } xfer_kind_e;

    typedef enum logic [1:0] {
        CH_IDLE  = 2'b00,
        CH_ARMED = 2'b01,
        CH_RUN   = 2'b10
    } ch_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] dev_addr;
        logic [EP_W-1:0]   ep;
        logic              dir_in;
        xfer_kind_e        kind;
        logic [MPS_W-1:0]  mps;
        logic              low_speed;
        logic              odd_frame;
    } chan_char_t;

    function automatic logic [1:0] pid_next(input logic [1:0] p);
        return {~p[1], 1'b0};
    endfunction

    function automatic logic is_periodic(input xfer_kind_e k);
        return (k == XK_ISO) || (k == XK_INTR);
    endfunction

endpackage

// File: rtl/hc_char_reg.sv
module hc_char_reg
    import hc_xfer_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  chan_char_t d,
    output chan_char_t q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end
endmodule

// File: rtl/hc_xfer_count.sv
module hc_xfer_count
    import hc_xfer_pkg::*;
#(
    parameter int BYTE_W = 19,
    parameter int PKT_W  = 10
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [BYTE_W-1:0] ld_bytes,
    input  logic [PKT_W-1:0]  ld_pkts,
    input  logic [1:0]        ld_pid,
    input  logic              step,
    input  logic [MPS_W-1:0]  step_len,
    input  logic              dir_in,
    input  logic [MPS_W-1:0]  mps,
    output logic [BYTE_W-1:0] bytes_q,
    output logic [PKT_W-1:0]  pkts_q,
    output logic [1:0]        pid_q,
    output logic              last_o
);
    localparam logic [PKT_W-1:0] ONE_PKT = PKT_W'(1);

    logic [BYTE_W-1:0] len_ext;
    logic [BYTE_W-1:0] bytes_nxt;

    assign len_ext   = BYTE_W'(step_len);
    assign bytes_nxt = (len_ext > bytes_q) ? '0 : bytes_q - len_ext;
    assign last_o    = (pkts_q <= ONE_PKT) || (dir_in && (step_len < mps));

    always_ff @(posedge clk) begin
        if (rst) begin
            bytes_q <= '0;
            pkts_q  <= '0;
            pid_q   <= 2'b00;
        end else if (load) begin
            bytes_q <= ld_bytes;
            pkts_q  <= ld_pkts;
            pid_q   <= ld_pid;
        end else if (step) begin
            bytes_q <= bytes_nxt;
            pkts_q  <= pkts_q - ONE_PKT;
            pid_q   <= pid_next(pid_q);
        end
    end
endmodule

// File: rtl/hc_chan_fsm.sv
module hc_chan_fsm
    import hc_xfer_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      en_set,
    input  logic      en_clr,
    input  logic      cfg_zero,
    input  logic      periodic,
    input  logic      odd_sel,
    input  logic      frame_lsb,
    input  logic      pkt_done,
    input  logic      last,
    output ch_state_e state_o,
    output logic      accept_o,
    output logic      done_o,
    output logic      halted_o
);
    ch_state_e state_q;
    logic      halt_req_q;
    logic      stop_now;
    logic      frame_ok;

    assign state_o  = state_q;
    assign accept_o = pkt_done && (state_q == CH_RUN);
    assign stop_now = en_clr || halt_req_q;
    assign frame_ok = !periodic || (frame_lsb == odd_sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= CH_IDLE;
            halt_req_q <= 1'b0;
            done_o     <= 1'b0;
            halted_o   <= 1'b0;
        end else begin
            done_o   <= 1'b0;
            halted_o <= 1'b0;
            unique case (state_q)
                CH_IDLE: begin
                    if (en_set) begin
                        if (cfg_zero) begin
                            done_o   <= 1'b1;
                            halted_o <= 1'b1;
                        end else begin
                            state_q    <= CH_ARMED;
                            halt_req_q <= 1'b0;
                        end
                    end
                end
                CH_ARMED: begin
                    if (stop_now) begin
                        halted_o   <= 1'b1;
                        halt_req_q <= 1'b0;
                        state_q    <= CH_IDLE;
                    end else if (frame_ok) begin
                        state_q <= CH_RUN;
                    end
                end
                CH_RUN: begin
                    if (pkt_done) begin
                        if (last) begin
                            done_o     <= 1'b1;
                            halted_o   <= 1'b1;
                            halt_req_q <= 1'b0;
                            state_q    <= CH_IDLE;
                        end else if (stop_now) begin
                            halted_o   <= 1'b1;
                            halt_req_q <= 1'b0;
                            state_q    <= CH_IDLE;
                        end
                    end else if (en_clr) begin
                        halt_req_q <= 1'b1;
                    end
                end
                default: state_q <= CH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/hchan_xfer_tracker.sv
module hchan_xfer_tracker
    import hc_xfer_pkg::*;
#(
    parameter int BYTE_W = 19,
    parameter int PKT_W  = 10
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [BYTE_W-1:0] cfg_bytes,
    input  logic [PKT_W-1:0]  cfg_pkts,
    input  logic [1:0]        cfg_pid,
    input  logic [6:0]        cfg_dev_addr,
    input  logic [3:0]        cfg_ep,
    input  logic              cfg_dir_in,
    input  logic [1:0]        cfg_kind,
    input  logic [10:0]       cfg_mps,
    input  logic              cfg_low_speed,
    input  logic              cfg_odd_frame,
    input  logic              en_set,
    input  logic              en_clr,
    input  logic              frame_lsb,
    input  logic              pkt_done,
    input  logic [10:0]       pkt_len,
    output logic              enabled_o,
    output logic              xfer_go_o,
    output logic [BYTE_W-1:0] bytes_left_o,
    output logic [PKT_W-1:0]  pkts_left_o,
    output logic [1:0]        pid_o,
    output logic [6:0]        dev_addr_o,
    output logic [3:0]        ep_o,
    output logic              dir_in_o,
    output logic [1:0]        kind_o,
    output logic [10:0]       mps_o,
    output logic              low_speed_o,
    output logic              odd_frame_o,
    output logic              done_o,
    output logic              halted_o
);
    ch_state_e  state;
    chan_char_t char_d;
    chan_char_t char_q;
    logic       load;
    logic       cfg_zero;
    logic       accept;
    logic       last;

    assign load = cfg_wr && (state == CH_IDLE);

    assign cfg_zero = cfg_wr ? (cfg_pkts == '0) : (pkts_left_o == '0);

    always_comb begin
        char_d.dev_addr  = cfg_dev_addr;
        char_d.ep        = cfg_ep;
        char_d.dir_in    = cfg_dir_in;
        char_d.kind      = xfer_kind_e'(cfg_kind);
        char_d.mps       = cfg_mps;
        char_d.low_speed = cfg_low_speed;
        char_d.odd_frame = cfg_odd_frame;
    end

    hc_char_reg u_char (
        .clk  (clk),
        .rst  (rst),
        .load (load),
        .d    (char_d),
        .q    (char_q)
    );

    hc_xfer_count #(
        .BYTE_W (BYTE_W),
        .PKT_W  (PKT_W)
    ) u_count (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .ld_bytes (cfg_bytes),
        .ld_pkts  (cfg_pkts),
        .ld_pid   (cfg_pid),
        .step     (accept),
        .step_len (pkt_len),
        .dir_in   (char_q.dir_in),
        .mps      (char_q.mps),
        .bytes_q  (bytes_left_o),
        .pkts_q   (pkts_left_o),
        .pid_q    (pid_o),
        .last_o   (last)
    );

    hc_chan_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .en_set    (en_set),
        .en_clr    (en_clr),
        .cfg_zero  (cfg_zero),
        .periodic  (is_periodic(char_q.kind)),
        .odd_sel   (char_q.odd_frame),
        .frame_lsb (frame_lsb),
        .pkt_done  (pkt_done),
        .last      (last),
        .state_o   (state),
        .accept_o  (accept),
        .done_o    (done_o),
        .halted_o  (halted_o)
    );

    assign enabled_o   = (state != CH_IDLE);
    assign xfer_go_o   = (state == CH_RUN);
    assign dev_addr_o  = char_q.dev_addr;
    assign ep_o        = char_q.ep;
    assign dir_in_o    = char_q.dir_in;
    assign kind_o      = char_q.kind;
    assign mps_o       = char_q.mps;
    assign low_speed_o = char_q.low_speed;
    assign odd_frame_o = char_q.odd_frame;
endmodule

// File: rtl/hchan_xfer_tracker_chk.sv
module hchan_xfer_tracker_chk #(
    parameter int PKT_W = 10
)(
    input logic             clk,
    input logic             rst,
    input logic             pkt_done,
    input logic             frame_lsb,
    input logic             enabled_o,
    input logic             xfer_go_o,
    input logic [PKT_W-1:0] pkts_left_o,
    input logic [1:0]       pid_o,
    input logic [6:0]       dev_addr_o,
    input logic [10:0]      mps_o,
    input logic [1:0]       kind_o,
    input logic             odd_frame_o,
    input logic             done_o,
    input logic             halted_o
);
    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (!enabled_o && !done_o && !halted_o));

    p_cfg_frozen_r3: assert property (@(posedge clk) disable iff (rst)
        enabled_o |=> ($stable(mps_o) && $stable(dev_addr_o) && $stable(kind_o)));

    p_go_needs_enable_r4: assert property (@(posedge clk) disable iff (rst)
        xfer_go_o |-> enabled_o);

    p_periodic_phase_r4: assert property (@(posedge clk) disable iff (rst)
        ($rose(xfer_go_o) && kind_o[0]) |-> ($past(frame_lsb) == odd_frame_o));

    p_pkt_step_r5: assert property (@(posedge clk) disable iff (rst)
        (pkt_done && xfer_go_o) |=> (pkts_left_o == $past(pkts_left_o) - PKT_W'(1)));

    p_pid_toggle_r5: assert property (@(posedge clk) disable iff (rst)
        (pkt_done && xfer_go_o) |=> (pid_o == {~$past(pid_o[1]), 1'b0}));

    p_done_with_halt_r6: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (halted_o && !enabled_o));

    p_halt_disables_r8: assert property (@(posedge clk) disable iff (rst)
        halted_o |-> !xfer_go_o);
endmodule

bind hchan_xfer_tracker hchan_xfer_tracker_chk #(.PKT_W(PKT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .pkt_done    (pkt_done),
    .frame_lsb   (frame_lsb),
    .enabled_o   (enabled_o),
    .xfer_go_o   (xfer_go_o),
    .pkts_left_o (pkts_left_o),
    .pid_o       (pid_o),
    .dev_addr_o  (dev_addr_o),
    .mps_o       (mps_o),
    .kind_o      (kind_o),
    .odd_frame_o (odd_frame_o),
    .done_o      (done_o),
    .halted_o    (halted_o)
);

// File: tb/tb_hchan_xfer_tracker.sv
module tb_hchan_xfer_tracker;
    localparam int BYTE_W = 19;
    localparam int PKT_W  = 10;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cfg_wr = 1'b0;
    logic [BYTE_W-1:0] cfg_bytes = '0;
    logic [PKT_W-1:0]  cfg_pkts = '0;
    logic [1:0]        cfg_pid = '0;
    logic [6:0]        cfg_dev_addr = '0;
    logic [3:0]        cfg_ep = '0;
    logic              cfg_dir_in = 1'b0;
    logic [1:0]        cfg_kind = '0;
    logic [10:0]       cfg_mps = '0;
    logic              cfg_low_speed = 1'b0;
    logic              cfg_odd_frame = 1'b0;
    logic              en_set = 1'b0;
    logic              en_clr = 1'b0;
    logic              frame_lsb = 1'b0;
    logic              pkt_done = 1'b0;
    logic [10:0]       pkt_len = '0;
    logic              enabled_o, xfer_go_o;
    logic [BYTE_W-1:0] bytes_left_o;
    logic [PKT_W-1:0]  pkts_left_o;
    logic [1:0]        pid_o;
    logic [6:0]        dev_addr_o;
    logic [3:0]        ep_o;
    logic              dir_in_o;
    logic [1:0]        kind_o;
    logic [10:0]       mps_o;
    logic              low_speed_o, odd_frame_o, done_o, halted_o;

    int n_chk  = 0;
    int n_fail = 0;

    int m_pkts, m_bytes, m_pid, m_mps;
    bit m_in;

    always #5 clk = ~clk;

    hchan_xfer_tracker #(.BYTE_W(BYTE_W), .PKT_W(PKT_W)) dut (.*);

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic configure(input int pkts, input int bytes, input int pid,
                             input int kind, input bit din, input int mps, input bit odd);
        cfg_pkts = PKT_W'(pkts); cfg_bytes = BYTE_W'(bytes); cfg_pid = 2'(pid);
        cfg_kind = 2'(kind); cfg_dir_in = din; cfg_mps = 11'(mps); cfg_odd_frame = odd;
        cfg_dev_addr = 7'($urandom); cfg_ep = 4'($urandom); cfg_low_speed = 1'($urandom);
        cfg_wr = 1'b1;
        tick();
        cfg_wr = 1'b0;
        m_pkts = pkts; m_bytes = bytes; m_pid = pid; m_mps = mps; m_in = din;
    endtask

    function automatic bit is_last(input int len);
        return (m_pkts <= 1) || (m_in && (len < m_mps));
    endfunction

    task automatic packet(input int len, input bit stop, output bit fin);
        bit lst;
        lst = is_last(len);
        pkt_done = 1'b1; pkt_len = 11'(len); en_clr = stop;
        tick();
        pkt_done = 1'b0; en_clr = 1'b0;
        m_pkts  = m_pkts - 1;
        m_bytes = (len > m_bytes) ? 0 : m_bytes - len;
        m_pid   = (m_pid == 0) ? 2 : 0;
        check("R5 pkts", int'(pkts_left_o), m_pkts);
        check("R5 bytes", int'(bytes_left_o), m_bytes);
        check("R5 pid", int'(pid_o), m_pid);
        check("R6 done", int'(done_o), int'(lst));
        check("R6 halted", int'(halted_o), int'(lst || stop));
        check("R6 enabled", int'(enabled_o), int'(!(lst || stop)));
        fin = lst || stop;
    endtask

    task automatic start(input bit periodic, input bit odd);
        en_set = 1'b1;
        tick();
        en_set = 1'b0;
        check("R4 enabled", int'(enabled_o), 1);
        check("R4 go late", int'(xfer_go_o), 0);
        if (periodic) begin
            frame_lsb = ~odd;
            tick();
            check("R4 periodic wait", int'(xfer_go_o), 0);
            frame_lsb = odd;
        end
        tick();
        check("R4 go", int'(xfer_go_o), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        bit fin;
        void'($urandom(32'd2024));
        repeat (3) tick();
        rst = 1'b0;
        // R1 reset state
        check("R1 enabled", int'(enabled_o), 0);
        check("R1 go", int'(xfer_go_o), 0);
        check("R1 pkts", int'(pkts_left_o), 0);
        check("R1 pid", int'(pid_o), 0);
        check("R1 done", int'(done_o | halted_o), 0);

        // R2 load while idle
        configure(3, 150, 0, 2, 1'b0, 64, 1'b0);
        check("R2 pkts", int'(pkts_left_o), 3);
        check("R2 bytes", int'(bytes_left_o), 150);
        check("R2 mps", int'(mps_o), 64);
        check("R2 kind", int'(kind_o), 2);
        check("R2 addr", int'(dev_addr_o), int'(cfg_dev_addr));
        // R4 enable; R5 packet during armed is ignored
        en_set = 1'b1; tick(); en_set = 1'b0;
        check("R4 enabled", int'(enabled_o), 1);
        pkt_done = 1'b1; pkt_len = 11'd64; tick(); pkt_done = 1'b0;
        check("R5 ignored before go", int'(pkts_left_o), 3);
        check("R4 go bulk", int'(xfer_go_o), 1);
        // R3 writes ignored while enabled
        cfg_pkts = 10'd9; cfg_mps = 11'd8; cfg_bytes = 19'd7; cfg_kind = 2'd1;
        cfg_wr = 1'b1; tick(); cfg_wr = 1'b0;
        check("R3 pkts", int'(pkts_left_o), 3);
        check("R3 mps", int'(mps_o), 64);
        check("R3 bytes", int'(bytes_left_o), 150);
        check("R3 kind", int'(kind_o), 2);
        // R5/R7 OUT short packet does not finish
        packet(64, 1'b0, fin);
        packet(30, 1'b0, fin);
        check("R7 out short keeps running", int'(enabled_o), 1);
        packet(56, 1'b0, fin);

        // R7 IN short ends early
        configure(4, 256, 2, 2, 1'b1, 64, 1'b0);
        start(1'b0, 1'b0);
        packet(64, 1'b0, fin);
        packet(10, 1'b0, fin);
        check("R7 in short", int'(fin), 1);

        // R8 stop while running
        configure(5, 320, 0, 0, 1'b0, 64, 1'b0);
        start(1'b0, 1'b0);
        en_clr = 1'b1; tick(); en_clr = 1'b0;
        check("R8 stop waits", int'(halted_o), 0);
        check("R8 still enabled", int'(enabled_o), 1);
        packet(64, 1'b1, fin);
        check("R8 halted no done", int'(done_o), 0);
        tick();
        check("R8 halted single", int'(halted_o), 0);

        // R8 stop before go
        configure(2, 20, 0, 2, 1'b0, 16, 1'b0);
        en_set = 1'b1; tick(); en_set = 1'b0;
        en_clr = 1'b1; tick(); en_clr = 1'b0;
        check("R8 armed halt", int'(halted_o), 1);
        check("R8 armed disable", int'(enabled_o), 0);

        // R9 stop with final packet
        configure(1, 40, 2, 2, 1'b0, 64, 1'b0);
        start(1'b0, 1'b0);
        packet(40, 1'b1, fin);
        check("R9 done with stop", int'(done_o & halted_o), 1);
        tick();
        check("R9 single pulse", int'(done_o | halted_o), 0);

        // R10 zero packet count
        configure(0, 0, 0, 2, 1'b0, 64, 1'b0);
        en_set = 1'b1; tick(); en_set = 1'b0;
        check("R10 pulses", int'(done_o & halted_o), 1);
        check("R10 disabled", int'(enabled_o), 0);

        // R4 periodic directed: interrupt on odd frames
        configure(2, 16, 0, 3, 1'b1, 8, 1'b1);
        start(1'b1, 1'b1);
        packet(8, 1'b0, fin);
        packet(8, 1'b0, fin);

        // constrained random transfers
        for (int t = 0; t < 25; t++) begin
            int kind, mps, pk, pid;
            bit din, odd;
            kind = int'($urandom % 4);
            mps  = 8 + int'($urandom % 57);
            pk   = 1 + int'($urandom % 6);
            pid  = ($urandom % 2) ? 2 : 0;
            din  = 1'($urandom);
            odd  = 1'($urandom);
            configure(pk, pk * mps - int'($urandom % 4), pid, kind, din, mps, odd);
            check("R2 random pkts", int'(pkts_left_o), pk);
            start(kind[0], odd);
            fin = 1'b0;
            while (!fin) begin
                int len;
                len = ($urandom % 4 == 0) ? int'($urandom % mps) : mps;
                packet(len, 1'b0, fin);
            end
        end

        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule